// File: doc/BRIEF.md
# Multi-Core Interrupt Claim Router

This block gathers level-sensitive interrupt requests from a set of peripheral sources and hands each one to exactly one processor core. A source whose request line is high becomes pending. Every core that is free sees a notification while at least one pending source waits. A core takes a source by raising its claim strobe. One cycle later the block answers with the source ID it granted, and from then on that source belongs to that core alone. When the core has finished its handler, it writes a completion that carries the same ID. The block then releases the core and re-arms the source.

Each source has a three-state machine: `SRC_IDLE`, `SRC_PENDING` and `SRC_CLAIMED`. Its transitions are raise (IDLE→PENDING when its line is high), take (PENDING→CLAIMED when a core is granted it) and release (CLAIMED→IDLE when the owning core completes it). Each core has a two-state machine: `CORE_FREE` and `CORE_BUSY`. Its transitions are T_CLAIM (FREE→BUSY when a claim is granted a non-zero ID) and T_DONE (BUSY→FREE when a completion matches the held ID). A combinational arbiter sits between the two arrays. It resolves claims made in the same cycle.

Top module: `irq_claim_router`

## Requirements
- R1: After reset all sources are idle and all cores are free, every notification is low and no claim response is valid.
- R2: A source whose request line is high while idle becomes pending at the next clock edge. Core c's notification is high exactly while core c is free and at least one source is pending.
- R3: A claim by a free core produces a response one cycle later: rsp_valid is high and rsp_id holds the lowest pending ID. That source is no longer pending, and the core becomes busy holding that ID.
- R4: When several free cores claim in the same cycle, the cores are served in ascending index order. Each core receives the lowest ID not already granted to a lower-indexed core, or 0 if none is left. No ID is ever owned by two cores.
- R5: A claim when no source is pending returns ID 0 and changes no state.
- R6: A claim by a busy core returns ID 0 and leaves that core's held ID and all source states unchanged.
- R7: A pending source that no core takes stays pending for as long as needed, including while all cores are busy.
- R8: A claimed source cannot become pending again until it is completed, even if its request line stays high.
- R9: A completion whose ID matches the completing core's held ID frees the core and returns the source to idle at that edge. If the source's line is still high, it becomes pending one edge later.
- R10: A completion from a core whose ID differs from the ID that core holds (or from a free core) is ignored.
- R11: ID 0 means "no interrupt". Request bit irq[k] is source ID k+1. Core c's ID fields are bits [c*ID_W +: ID_W] of rsp_id and cmpl_id, with ID_W = clog2(N_SRC+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | N_SRC | Level request lines; bit k is source ID k+1 |
| notify | output | N_CORE | Per-core "free and work waiting" indication |
| claim_req | input | N_CORE | Per-core claim strobe |
| rsp_valid | output | N_CORE | Per-core claim response valid, one cycle after claim |
| rsp_id | output | N_CORE*ID_W | Per-core granted source ID (0 = none) |
| cmpl_valid | input | N_CORE | Per-core completion strobe |
| cmpl_id | input | N_CORE*ID_W | Per-core completed source ID |

## Verification
A line raised before an edge is pending after that edge, so the notification is due at the next falling edge. A claim response appears at the first falling edge after the claim edge. A completed source can be re-claimed no earlier than two edges after its completion. The bench drives all inputs on the falling edge and runs a behavioural reference model on the rising edge. It compares notify, rsp_valid and rsp_id against that model on every falling edge. Directed checks sample at the cycles named above for each corner case: simultaneous claims, empty claims, claims by busy cores, wrong-ID completions and re-arming.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_PENDING = 2'd1,
        SRC_CLAIMED = 2'd2
    } src_state_e;

    typedef enum logic {
        CORE_FREE = 1'b0,
        CORE_BUSY = 1'b1
    } core_state_e;
endpackage

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic take,
    input  logic release_i,
    output logic pending,
    output logic claimed
);
    src_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:    if (irq)       state_d = SRC_PENDING;
            SRC_PENDING: if (take)      state_d = SRC_CLAIMED;
            SRC_CLAIMED: if (release_i) state_d = SRC_IDLE;
            default:                    state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == SRC_PENDING);
        claimed = (state_q == SRC_CLAIMED);
    end
endmodule

// File: rtl/irq_core_fsm.sv
module irq_core_fsm
    import irq_route_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            claim_req,
    input  logic [ID_W-1:0] grant_id,
    input  logic            cmpl_valid,
    input  logic [ID_W-1:0] cmpl_id,
    output logic            busy,
    output logic            claim_eff,
    output logic            cmpl_ok,
    output logic [ID_W-1:0] held_id,
    output logic            rsp_valid,
    output logic [ID_W-1:0] rsp_id
);
    core_state_e state_q, state_d;
    logic [ID_W-1:0] held_d;
    logic [ID_W-1:0] rsp_id_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CORE_FREE;
            held_id   <= '0;
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
        end else begin
            state_q   <= state_d;
            held_id   <= held_d;
            rsp_valid <= claim_req;
            rsp_id    <= rsp_id_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        held_d   = held_id;
        rsp_id_d = '0;
        unique case (state_q)
            CORE_FREE: begin
                if (claim_req && grant_id != '0) begin
                    state_d  = CORE_BUSY;
                    held_d   = grant_id;
                    rsp_id_d = grant_id;
                end
            end
            CORE_BUSY: begin
                if (cmpl_ok) begin
                    state_d = CORE_FREE;
                    held_d  = '0;
                end
            end
            default: state_d = CORE_FREE;
        endcase
    end

    always_comb begin
        busy      = (state_q == CORE_BUSY);
        claim_eff = claim_req && (state_q == CORE_FREE);
        cmpl_ok   = (state_q == CORE_BUSY) && cmpl_valid &&
                    (cmpl_id == held_id) && (cmpl_id != '0);
    end
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
    parameter int N_SRC  = 8,
    parameter int N_CORE = 3,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC-1:0]             pending,
    input  logic [N_CORE-1:0]            req,
    output logic [N_CORE-1:0][ID_W-1:0]  grant_id,
    output logic [N_SRC-1:0]             taken
);
    logic [N_SRC-1:0] avail;
    logic             hit;

    always_comb begin
        avail    = pending;
        taken    = '0;
        grant_id = '0;
        hit      = 1'b0;
        for (int c = 0; c < N_CORE; c++) begin
            hit = 1'b0;
            if (req[c]) begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (!hit && avail[s]) begin
                        hit         = 1'b1;
                        grant_id[c] = ID_W'(s + 1);
                        avail[s]    = 1'b0;
                        taken[s]    = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_claim_router.sv
module irq_claim_router #(
    parameter int N_SRC  = 8,
    parameter int N_CORE = 3,
    localparam int ID_W  = $clog2(N_SRC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq,
    output logic [N_CORE-1:0]      notify,
    input  logic [N_CORE-1:0]      claim_req,
    output logic [N_CORE-1:0]      rsp_valid,
    output logic [N_CORE*ID_W-1:0] rsp_id,
    input  logic [N_CORE-1:0]      cmpl_valid,
    input  logic [N_CORE*ID_W-1:0] cmpl_id
);
    logic [N_SRC-1:0]            pending;
    logic [N_SRC-1:0]            claimed;
    logic [N_SRC-1:0]            taken;
    logic [N_SRC-1:0]            release_vec;
    logic [N_CORE-1:0]           busy;
    logic [N_CORE-1:0]           claim_eff;
    logic [N_CORE-1:0]           cmpl_ok;
    logic [N_CORE-1:0][ID_W-1:0] grant_id;
    logic [N_CORE-1:0][ID_W-1:0] held_id;
    logic                        any_pending;

    irq_claim_arbiter #(.N_SRC(N_SRC), .N_CORE(N_CORE), .ID_W(ID_W)) arb_i (
        .pending  (pending),
        .req      (claim_eff),
        .grant_id (grant_id),
        .taken    (taken)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        irq_src_fsm src_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq       (irq[s]),
            .take      (taken[s]),
            .release_i (release_vec[s]),
            .pending   (pending[s]),
            .claimed   (claimed[s])
        );
    end

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        irq_core_fsm #(.ID_W(ID_W)) core_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .claim_req  (claim_req[c]),
            .grant_id   (grant_id[c]),
            .cmpl_valid (cmpl_valid[c]),
            .cmpl_id    (cmpl_id[c*ID_W +: ID_W]),
            .busy       (busy[c]),
            .claim_eff  (claim_eff[c]),
            .cmpl_ok    (cmpl_ok[c]),
            .held_id    (held_id[c]),
            .rsp_valid  (rsp_valid[c]),
            .rsp_id     (rsp_id[c*ID_W +: ID_W])
        );
    end

    // A source is released only by the core that currently holds its ID.
    always_comb begin
        release_vec = '0;
        for (int s = 0; s < N_SRC; s++) begin
            for (int c = 0; c < N_CORE; c++) begin
                if (cmpl_ok[c] && held_id[c] == ID_W'(s + 1))
                    release_vec[s] = 1'b1;
            end
        end
    end

    assign any_pending = |pending;
    assign notify      = ~busy & {N_CORE{any_pending}};
endmodule

// File: rtl/irq_claim_router_chk.sv
module irq_claim_router_chk #(
    parameter int N_SRC  = 8,
    parameter int N_CORE = 3,
    parameter int ID_W   = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [N_CORE-1:0]             claim_req,
    input logic [N_CORE-1:0]             cmpl_valid,
    input logic [N_CORE*ID_W-1:0]        cmpl_id,
    input logic [N_CORE-1:0]             rsp_valid,
    input logic [N_CORE*ID_W-1:0]        rsp_id,
    input logic [N_SRC-1:0]              pending,
    input logic [N_SRC-1:0]              claimed,
    input logic [N_SRC-1:0]              taken,
    input logic [N_CORE-1:0]             busy,
    input logic [N_CORE-1:0][ID_W-1:0]   held_id
);
    for (genvar s = 0; s < N_SRC; s++) begin : g_s
        logic [N_CORE-1:0] holders;
        always_comb begin
            for (int c = 0; c < N_CORE; c++)
                holders[c] = busy[c] && (held_id[c] == ID_W'(s + 1));
        end

        p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(holders) <= 1);
        p_claim_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
            claimed[s] |-> $countones(holders) == 1);
        p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
            claimed[s] |=> (claimed[s] || !pending[s]));
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[s] && !taken[s]) |=> pending[s]);
    end

    for (genvar c = 0; c < N_CORE; c++) begin : g_c
        p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_req[c] && pending == '0) |=>
                (rsp_valid[c] && rsp_id[c*ID_W +: ID_W] == '0));
        p_busy_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_req[c] && busy[c]) |=>
                (rsp_valid[c] && rsp_id[c*ID_W +: ID_W] == '0));
        p_grant_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[c] && rsp_id[c*ID_W +: ID_W] != '0) |->
                (busy[c] && held_id[c] == rsp_id[c*ID_W +: ID_W]));
        p_bad_cmpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[c] && cmpl_valid[c] && cmpl_id[c*ID_W +: ID_W] != held_id[c]) |=>
                (busy[c] && $stable(held_id[c])));
    end
endmodule

bind irq_claim_router irq_claim_router_chk #(
    .N_SRC(N_SRC), .N_CORE(N_CORE), .ID_W(ID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim_req  (claim_req),
    .cmpl_valid (cmpl_valid),
    .cmpl_id    (cmpl_id),
    .rsp_valid  (rsp_valid),
    .rsp_id     (rsp_id),
    .pending    (pending),
    .claimed    (claimed),
    .taken      (taken),
    .busy       (busy),
    .held_id    (held_id)
);

// File: tb/irq_claim_router_tb_top.sv
`timescale 1ns/1ps
module irq_claim_router_tb_top;
    localparam int N_SRC  = 8;
    localparam int N_CORE = 3;
    localparam int ID_W   = $clog2(N_SRC + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N_SRC-1:0]       irq = '0;
    logic [N_CORE-1:0]      notify;
    logic [N_CORE-1:0]      claim_req = '0;
    logic [N_CORE-1:0]      rsp_valid;
    logic [N_CORE*ID_W-1:0] rsp_id;
    logic [N_CORE-1:0]      cmpl_valid = '0;
    logic [N_CORE*ID_W-1:0] cmpl_id = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    irq_claim_router #(.N_SRC(N_SRC), .N_CORE(N_CORE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq(irq), .notify(notify),
        .claim_req(claim_req), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id)
    );

    // Behavioural reference: 0 idle, 1 pending, 2 claimed
    int m_src [N_SRC+1];
    bit m_busy[N_CORE];
    int m_held[N_CORE];
    bit e_rv  [N_CORE];
    int e_rid [N_CORE];

    function automatic int rid(int c);
        return int'(rsp_id[c*ID_W +: ID_W]);
    endfunction

    function automatic int cid(int c);
        return int'(cmpl_id[c*ID_W +: ID_W]);
    endfunction

    always @(posedge clk) begin
        int os[N_SRC+1];
        bit ob[N_CORE];
        int oh[N_CORE];
        bit tk[N_SRC+1];
        if (!rst_n) begin
            for (int s = 0; s <= N_SRC; s++) m_src[s] = 0;
            for (int c = 0; c < N_CORE; c++) begin
                m_busy[c] = 0; m_held[c] = 0; e_rv[c] = 0; e_rid[c] = 0;
            end
        end else begin
            os = m_src; ob = m_busy; oh = m_held;
            for (int s = 0; s <= N_SRC; s++) tk[s] = 0;
            for (int c = 0; c < N_CORE; c++) begin
                e_rv[c] = claim_req[c];
                e_rid[c] = 0;
                if (claim_req[c] && !ob[c]) begin
                    for (int s = 1; s <= N_SRC; s++) begin
                        if (e_rid[c] == 0 && os[s] == 1 && !tk[s]) begin
                            tk[s] = 1; e_rid[c] = s;
                            m_src[s] = 2; m_busy[c] = 1; m_held[c] = s;
                        end
                    end
                end
            end
            for (int c = 0; c < N_CORE; c++) begin
                if (cmpl_valid[c] && ob[c] && cid(c) == oh[c] && oh[c] != 0) begin
                    m_src[oh[c]] = 0; m_busy[c] = 0; m_held[c] = 0;
                end
            end
            for (int s = 1; s <= N_SRC; s++)
                if (os[s] == 0 && irq[s-1]) m_src[s] = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        bit anyp;
        if (rst_n) begin
            anyp = 0;
            for (int s = 1; s <= N_SRC; s++) if (m_src[s] == 1) anyp = 1;
            for (int c = 0; c < N_CORE; c++) begin
                check(notify[c] == (!m_busy[c] && anyp), "R2 notify vs model",
                      int'(notify[c]), int'(!m_busy[c] && anyp));
                check(rsp_valid[c] == e_rv[c], "R3 rsp_valid vs model",
                      int'(rsp_valid[c]), int'(e_rv[c]));
                if (e_rv[c])
                    check(rid(c) == e_rid[c], "R4 rsp_id vs model", rid(c), e_rid[c]);
            end
        end
    end

    task automatic claim(input logic [N_CORE-1:0] m);
        claim_req = m;
        @(negedge clk);
        claim_req = '0;
    endtask

    task automatic complete(input int c, input int id);
        cmpl_valid[c] = 1'b1;
        cmpl_id[c*ID_W +: ID_W] = ID_W'(id);
        @(negedge clk);
        cmpl_valid = '0;
        cmpl_id = '0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(notify == '0, "R1 notify", int'(notify), 0);
        check(rsp_valid == '0, "R1 rsp_valid", int'(rsp_valid), 0);

        // R11: bits 2 and 4 are IDs 3 and 5
        irq = 8'b0001_0100;
        @(negedge clk);
        check(notify == 3'b111, "R2 notify all free", int'(notify), 7);

        claim(3'b011);
        check(rsp_valid == 3'b011, "R4 both respond", int'(rsp_valid), 3);
        check(rid(0) == 3, "R3 R11 lowest ID to core0", rid(0), 3);
        check(rid(1) == 5, "R4 next ID to core1", rid(1), 5);
        check(notify == '0, "R3 claimed no longer pending", int'(notify), 0);

        repeat (3) @(negedge clk);
        check(notify == '0, "R8 claimed masked", int'(notify), 0);

        claim(3'b100);
        check(rsp_valid[2] && rid(2) == 0, "R5 empty claim", rid(2), 0);
        @(negedge clk);
        check(notify == '0, "R5 no state change", int'(notify), 0);

        irq[0] = 1'b1;
        @(negedge clk);
        check(notify == 3'b100, "R2 free core notified", int'(notify), 4);
        claim(3'b001);
        check(rsp_valid[0] && rid(0) == 0, "R6 busy claim", rid(0), 0);
        check(notify == 3'b100, "R6 source untouched", int'(notify), 4);
        claim(3'b100);
        check(rid(2) == 1, "R3 core2 takes ID1", rid(2), 1);

        irq[6] = 1'b1;
        repeat (4) @(negedge clk);
        check(notify == '0, "R7 all busy", int'(notify), 0);

        complete(1, 3);
        check(notify[1] == 1'b0, "R10 wrong ID ignored", int'(notify[1]), 0);
        claim(3'b010);
        check(rid(1) == 0, "R10 core1 still busy", rid(1), 0);

        complete(1, 5);
        check(notify == 3'b010, "R9 core freed", int'(notify), 2);
        @(negedge clk);
        claim(3'b010);
        check(rid(1) == 5, "R9 re-armed source", rid(1), 5);

        irq[2] = 1'b0;
        complete(0, 3);
        @(negedge clk);
        claim(3'b001);
        check(rid(0) == 7, "R7 held request granted", rid(0), 7);
        @(negedge clk);
        check(notify == '0, "R8 nothing left pending", int'(notify), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule